// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block sits at the head of a transmit packet queue and decides when each queued packet may leave toward the converter. Packets arrive as a stream of 32-bit words with a valid/ready handshake. Each packet is a fixed 128 words. Two header words come first: the first carries the payload byte count and the burst markers, and the second carries a launch time. Payload samples follow, and padding fills out the rest of the packet. A free-running sample-time counter advances on each sample tick. When the header is read, the scheduler compares the launch time with that counter. It then holds the packet until the launch tick arrives, releases it at once, or discards it.

Payload samples leave at one per tick on a registered output, each tagged with the tick time at which it was issued. The scheduler follows burst state from the start and end markers. An empty queue is reported as an underrun only while a burst is open, never in the quiet gap after a burst has ended. Discarded packets and underruns set sticky status bits. The receive-side packetizer reads these bits and clears them with a one-cycle pulse.

Top module: `txq_launch`

## Requirements
- R1: After reset the scheduler waits for a header (in_ready_o high), issues no sample, both status bits are low, and the sample-time counter reads zero.
- R2: The sample-time counter on now_o increases by exactly one on each clock where tick_i is high, holds otherwise, and wraps modulo 2^32.
- R3: Header word 0 holds the payload byte count in bits 8:0, start-of-burst in bit 28 and end-of-burst in bit 27; all its other bits are ignored. Header word 1 is the launch time. A packet carries floor(count/4) samples, and any trailing partial word is treated as padding.
- R4: A packet whose launch time lies in the future is held at the queue head. Its first sample is issued on the tick at which now_o equals the launch time, so the first smp_time_o equals the launch time.
- R5: Samples of one released packet are issued one per tick with no gaps while the queue supplies them, so smp_time_o advances by one from sample to sample.
- R6: A launch time of 0xFFFFFFFF means "now": the first sample goes out on the first tick after the header, with no time comparison.
- R7: A packet whose launch time is already behind now_o, judged by the sign of the 32-bit difference (launch − now), is discarded with no sample issued, and dropped_o is set.
- R8: A payload byte count above 504 marks the packet malformed. It is discarded whatever its launch time, and dropped_o is set.
- R9: Every packet, whether sent, zero-length or discarded, consumes exactly 128 words. The word after it is always taken as the next header.
- R10: underrun_o is set when a tick finds the input empty while a burst is open and a sample or header is awaited. Outside a burst an empty input never sets it.
- R11: A released packet with start-of-burst opens a burst. A burst closes after the last sample of a released packet with end-of-burst has been issued.
- R12: dropped_o and underrun_o stay set until a clr_i pulse clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample tick: advances time and paces sample issue |
| clr_i | input | 1 | Clear pulse for the sticky status bits |
| in_data_i | input | 32 | Queue word |
| in_valid_i | input | 1 | Queue word present |
| in_ready_o | output | 1 | Word accepted on this clock when valid |
| smp_data_o | output | 32 | Issued payload sample |
| smp_vld_o | output | 1 | Sample valid, one cycle per issued sample |
| smp_time_o | output | 32 | Tick time at which the sample was issued |
| now_o | output | 32 | Current sample-time counter |
| dropped_o | output | 1 | Sticky: a packet was discarded |
| underrun_o | output | 1 | Sticky: a burst ran out of samples |

## Verification
A sample accepted at a clock edge appears on smp_vld_o, smp_data_o and smp_time_o one cycle after that edge. The bench therefore lets a few cycles pass after the last packet word before it reads its log of samples. Status bits react one cycle after the header word or the empty tick that triggers them, and the bench reads them only after an idle gap of many ticks. Launch times are checked against the smp_time_o tag rather than by counting cycles, which keeps the checks independent of the tick spacing. All inputs change just after the falling edge and all outputs are read in the low phase.

// File: rtl/txq_launch_pkg.sv
package txq_launch_pkg;

    typedef enum logic [2:0] {
        ST_HDR0 = 3'd0,
        ST_HDR1 = 3'd1,
        ST_WAIT = 3'd2,
        ST_SEND = 3'd3,
        ST_PAD  = 3'd4,
        ST_DROP = 3'd5
    } sched_state_t;

    // header word 0 field positions (decoded by the queue writer too)
    localparam int SOB_BIT = 28;
    localparam int EOB_BIT = 27;

endpackage

// File: rtl/txq_launch_time.sv
module txq_launch_time #(
    parameter int TS_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic [TS_W-1:0] cmp_i,
    output logic [TS_W-1:0] now_o,
    output logic            late_o,
    output logic            due_o
);

    logic [TS_W-1:0] now_d, now_q;
    logic [TS_W-1:0] diff;

    always_comb begin
        now_d = now_q;
        if (tick_i) begin
            now_d = now_q + TS_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            now_q <= '0;
        end else begin
            now_q <= now_d;
        end
    end

    // wrap-aware: negative difference means the launch time has passed
    assign diff   = cmp_i - now_q;
    assign late_o = diff[TS_W-1];
    assign due_o  = (diff == '0);
    assign now_o  = now_q;

    AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (now_q == $past(now_q) + TS_W'(1))); // R2
    AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(now_q)); // R2

endmodule

// File: rtl/txq_launch_flags.sv
module txq_launch_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic drop_ev_i,
    input  logic starve_i,
    input  logic burst_set_i,
    input  logic burst_clr_i,
    output logic dropped_o,
    output logic underrun_o,
    output logic burst_o
);

    typedef struct packed {
        logic dropped;
        logic underrun;
        logic burst;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr_i) begin
            f_d.dropped  = 1'b0;
            f_d.underrun = 1'b0;
        end
        if (drop_ev_i) begin
            f_d.dropped = 1'b1;
        end
        if (starve_i && f_q.burst) begin
            f_d.underrun = 1'b1;
        end
        if (burst_clr_i) begin
            f_d.burst = 1'b0;
        end else if (burst_set_i) begin
            f_d.burst = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dropped_o  = f_q.dropped;
    assign underrun_o = f_q.underrun;
    assign burst_o    = f_q.burst;

    AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.dropped && !clr_i) |=> f_q.dropped); // R12
    AST_UNDER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.underrun && !clr_i) |=> f_q.underrun); // R12
    AST_UNDER_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!f_q.underrun && !f_q.burst) |=> !f_q.underrun); // R10

endmodule

// File: rtl/txq_launch.sv
module txq_launch
    import txq_launch_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TS_W      = 32,
    parameter int LEN_W     = 9,
    parameter int PKT_WORDS = 128,
    parameter int HDR_WORDS = 2,
    parameter int MAX_LEN   = 504
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic [DATA_W-1:0] smp_data_o,
    output logic              smp_vld_o,
    output logic [TS_W-1:0]   smp_time_o,
    output logic [TS_W-1:0]   now_o,
    output logic              dropped_o,
    output logic              underrun_o
);

    localparam int BODY_WORDS = PKT_WORDS - HDR_WORDS;
    localparam int REM_W      = $clog2(BODY_WORDS + 1);
    localparam int SMP_SHIFT  = $clog2(DATA_W / 8);
    localparam logic [TS_W-1:0] NOW_STAMP = '1;

    typedef struct packed {
        sched_state_t      st;
        logic [LEN_W-1:0]  len;
        logic              sob;
        logic              eob;
        logic [TS_W-1:0]   ts;
        logic [REM_W-1:0]  rem;
        logic [REM_W-1:0]  left;
        logic [DATA_W-1:0] smp;
        logic              smp_vld;
        logic [TS_W-1:0]   smp_time;
    } regs_t;

    regs_t r_d, r_q;

    logic [TS_W-1:0]  now;
    logic [TS_W-1:0]  cmp;
    logic             late;
    logic             due;
    logic             burst;
    logic             drop_ev;
    logic             starve;
    logic             burst_set;
    logic             burst_clr;
    logic             issue;
    logic [REM_W-1:0] nsamp;

    assign cmp   = (r_q.st == ST_HDR1) ? in_data_i[TS_W-1:0] : r_q.ts;
    assign nsamp = REM_W'(r_q.len >> SMP_SHIFT);

    txq_launch_time #(
        .TS_W(TS_W)
    ) u_time (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .cmp_i  (cmp),
        .now_o  (now),
        .late_o (late),
        .due_o  (due)
    );

    txq_launch_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (clr_i),
        .drop_ev_i   (drop_ev),
        .starve_i    (starve),
        .burst_set_i (burst_set),
        .burst_clr_i (burst_clr),
        .dropped_o   (dropped_o),
        .underrun_o  (underrun_o),
        .burst_o     (burst)
    );

    always_comb begin
        r_d         = r_q;
        r_d.smp_vld = 1'b0;
        in_ready_o  = 1'b0;
        drop_ev     = 1'b0;
        starve      = 1'b0;
        burst_set   = 1'b0;
        burst_clr   = 1'b0;
        issue       = 1'b0;

        unique case (r_q.st)
            ST_HDR0: begin
                in_ready_o = 1'b1;
                starve     = tick_i && !in_valid_i;
                if (in_valid_i) begin
                    r_d.len = in_data_i[LEN_W-1:0];
                    r_d.sob = in_data_i[SOB_BIT];
                    r_d.eob = in_data_i[EOB_BIT];
                    r_d.st  = ST_HDR1;
                end
            end
            ST_HDR1: begin
                in_ready_o = 1'b1;
                starve     = tick_i && !in_valid_i;
                if (in_valid_i) begin
                    r_d.ts   = in_data_i[TS_W-1:0];
                    r_d.rem  = REM_W'(BODY_WORDS);
                    r_d.left = nsamp;
                    if ((r_q.len > LEN_W'(MAX_LEN)) ||
                        ((in_data_i[TS_W-1:0] != NOW_STAMP) && late)) begin
                        drop_ev = 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        burst_set = r_q.sob;
                        if (nsamp == '0) begin
                            burst_clr = r_q.eob;
                            r_d.st    = ST_PAD;
                        end else if (in_data_i[TS_W-1:0] == NOW_STAMP) begin
                            r_d.st = ST_SEND;
                        end else begin
                            r_d.st = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (late) begin
                    drop_ev = 1'b1;
                    r_d.st  = ST_DROP;
                end else if (due && tick_i) begin
                    in_ready_o = 1'b1;
                    r_d.st     = ST_SEND;
                    issue      = in_valid_i;
                end
            end
            ST_SEND: begin
                in_ready_o = tick_i;
                starve     = tick_i && !in_valid_i;
                issue      = tick_i && in_valid_i;
            end
            ST_PAD, ST_DROP: begin
                in_ready_o = 1'b1;
                if (in_valid_i) begin
                    r_d.rem = r_q.rem - REM_W'(1);
                    if (r_q.rem == REM_W'(1)) begin
                        r_d.st = ST_HDR0;
                    end
                end
            end
            default: begin
                r_d.st = ST_HDR0;
            end
        endcase

        if (issue) begin
            r_d.smp      = in_data_i;
            r_d.smp_vld  = 1'b1;
            r_d.smp_time = now;
            r_d.rem      = r_q.rem - REM_W'(1);
            r_d.left     = r_q.left - REM_W'(1);
            if (r_q.left == REM_W'(1)) begin
                burst_clr = r_q.eob;
                r_d.st    = (r_q.rem == REM_W'(1)) ? ST_HDR0 : ST_PAD;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign smp_data_o = r_q.smp;
    assign smp_vld_o  = r_q.smp_vld;
    assign smp_time_o = r_q.smp_time;
    assign now_o      = now;

    AST_SEND_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_SEND && in_ready_o) |-> tick_i); // R5
    AST_SMP_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_o |-> $past(tick_i)); // R5
    AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_DROP) |=> !smp_vld_o); // R7
    AST_MALFORMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_HDR1 && in_valid_i && r_q.len > LEN_W'(MAX_LEN))
        |=> (r_q.st == ST_DROP && dropped_o)); // R8
    AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_WAIT && !due) |-> !in_ready_o); // R4

endmodule

// File: tb/txq_launch_bench.sv
module txq_launch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] smp_data;
    logic        smp_vld;
    logic [31:0] smp_time;
    logic [31:0] now;
    logic        dropped;
    logic        underrun;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] log_d [0:1023];
    logic [31:0] log_t [0:1023];
    int nlog = 0;

    always #4 clk = ~clk;

    txq_launch u_txq_launch (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .clr_i      (clr),
        .in_data_i  (in_data),
        .in_valid_i (in_valid),
        .in_ready_o (in_ready),
        .smp_data_o (smp_data),
        .smp_vld_o  (smp_vld),
        .smp_time_o (smp_time),
        .now_o      (now),
        .dropped_o  (dropped),
        .underrun_o (underrun)
    );

    always @(negedge clk) begin
        cyc  <= cyc + 1;
        tick <= ((cyc % 4) == 0);
        if (rst_n && smp_vld && nlog < 1024) begin
            log_d[nlog] = smp_data;
            log_t[nlog] = smp_time;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        bit taken;
        @(negedge clk);
        #1;
        in_data  = w;
        in_valid = 1'b1;
        taken    = 1'b0;
        while (!taken) begin
            #2;
            if (in_ready) begin
                taken = 1'b1;
                @(posedge clk);
            end else begin
                @(negedge clk);
                #1;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic send_pkt(input logic [8:0] len, input bit sob, input bit eob,
                            input logic [31:0] ts, input logic [31:0] base);
        logic [31:0] w0;
        w0        = 32'h0065_1A00;   // junk in ignored fields
        w0[8:0]   = len;
        w0[28]    = sob;
        w0[27]    = eob;
        push(w0);
        push(ts);
        for (int i = 0; i < 126; i++) begin
            push((i < int'(len) / 4) ? base + 32'(i) : 32'hDEAD_0000 + 32'(i));
        end
    endtask

    // check a packet's logged samples against expected launch and data
    task automatic chk_samples(input int start, input int cnt, input logic [31:0] t0,
                               input logic [31:0] base, input string req);
        chk(nlog - start == cnt, req, 32'(nlog - start), 32'(cnt));
        for (int i = 0; i < cnt && start + i < nlog; i++) begin
            chk(log_t[start+i] == t0 + 32'(i), req, log_t[start+i], t0 + 32'(i));
            chk(log_d[start+i] == base + 32'(i), "R3 data", log_d[start+i], base + 32'(i));
        end
    endtask

    task automatic pulse_clr;
        @(negedge clk);
        #1;
        clr = 1'b1;
        @(negedge clk);
        #1;
        clr = 1'b0;
        #2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL R5 watchdog expired actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int st;
        logic [31:0] ts;
        logic [31:0] n0;
        logic [31:0] n1;

        repeat (4) @(negedge clk);
        #3;
        // R1: reset state
        chk(now == 32'h0, "R1 now", now, 32'h0);
        chk(in_ready == 1'b1, "R1 ready", {31'h0, in_ready}, 32'h1);
        chk(smp_vld == 1'b0, "R1 vld", {31'h0, smp_vld}, 32'h0);
        chk(dropped == 1'b0 && underrun == 1'b0, "R1 flags",
            {30'h0, dropped, underrun}, 32'h0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;

        // R2: counter advances once per tick
        idle(2);
        n0 = now;
        idle(40);
        chk(now - n0 == 32'd10, "R2 tick count", now - n0, 32'd10);

        // R4/R5/R3: timed packets, sweep of byte counts
        for (int L = 0; L <= 40; L += 3) begin
            st = nlog;
            ts = now + 32'd40;
            send_pkt(9'(L), 1'b0, 1'b0, ts, 32'h1000_0000 + 32'(L << 8));
            idle(3);
            chk_samples(st, L / 4, ts, 32'h1000_0000 + 32'(L << 8), "R4 launch");
        end
        chk(underrun == 1'b0, "R10 no burst no underrun", {31'h0, underrun}, 32'h0);
        chk(dropped == 1'b0, "R7 no drop on time", {31'h0, dropped}, 32'h0);

        // R6: immediate launch
        st = nlog;
        n0 = now;
        send_pkt(9'd12, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h2000_0000);
        idle(3);
        chk(nlog - st == 3, "R6 count", 32'(nlog - st), 32'd3);
        chk(log_t[st] - n0 <= 32'd2, "R6 first tick", log_t[st] - n0, 32'd2);
        chk_samples(st, 3, log_t[st], 32'h2000_0000, "R6 spacing");

        // R7: just late
        st = nlog;
        send_pkt(9'd16, 1'b0, 1'b0, now - 32'd1, 32'h3000_0000);
        idle(3);
        chk(nlog == st, "R7 no sample", 32'(nlog - st), 32'd0);
        chk(dropped == 1'b1, "R7 dropped", {31'h0, dropped}, 32'h1);
        idle(20);
        chk(dropped == 1'b1, "R12 sticky", {31'h0, dropped}, 32'h1);
        pulse_clr();
        chk(dropped == 1'b0, "R12 cleared", {31'h0, dropped}, 32'h0);

        // R7: far in the past, wrap-aware
        st = nlog;
        send_pkt(9'd8, 1'b0, 1'b0, now - 32'h7FFF_FFF0, 32'h3100_0000);
        idle(3);
        chk(nlog == st && dropped == 1'b1, "R7 far past",
            {31'h0, dropped}, 32'h1);
        pulse_clr();

        // R8: malformed count, then R9 alignment of the next packet
        st = nlog;
        send_pkt(9'd505, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h4000_0000);
        idle(3);
        chk(nlog == st, "R8 no sample", 32'(nlog - st), 32'd0);
        chk(dropped == 1'b1, "R8 dropped", {31'h0, dropped}, 32'h1);
        pulse_clr();
        st = nlog;
        ts = now + 32'd36;
        send_pkt(9'd20, 1'b0, 1'b0, ts, 32'h4100_0000);
        idle(3);
        chk_samples(st, 5, ts, 32'h4100_0000, "R9 aligned after drop");

        // R9: full payload, no padding
        st = nlog;
        ts = now + 32'd36;
        send_pkt(9'd504, 1'b0, 1'b0, ts, 32'h5000_0000);
        idle(3);
        chk_samples(st, 126, ts, 32'h5000_0000, "R9 full");
        st = nlog;
        send_pkt(9'd4, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h5100_0000);
        idle(3);
        chk(nlog - st == 1 && log_d[st] == 32'h5100_0000, "R9 next header",
            log_d[st], 32'h5100_0000);

        // R10/R11: open burst starves
        send_pkt(9'd8, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h6000_0000);
        idle(48);
        chk(underrun == 1'b1, "R10 underrun in burst", {31'h0, underrun}, 32'h1);
        // R11: end of burst closes it
        send_pkt(9'd8, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h6100_0000);
        idle(3);
        pulse_clr();
        chk(underrun == 1'b0, "R12 underrun cleared", {31'h0, underrun}, 32'h0);
        idle(48);
        chk(underrun == 1'b0, "R11 gap after burst", {31'h0, underrun}, 32'h0);

        // R11: zero-length packet carrying both markers leaves no burst
        send_pkt(9'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h7000_0000);
        idle(48);
        chk(underrun == 1'b0, "R11 zero-length burst", {31'h0, underrun}, 32'h0);

        n1 = now;
        chk(n1 != 32'h0, "R2 running", n1, 32'h1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule